// File: doc/BRIEF.md
# Programmable cyclic wake-up timer

This block paces the low-power period of a system controller. It holds a 3-bit interval code, which is loaded through the shared timing register only when that register's select bit is 1. A separate configuration bit widens every interval step eightfold. Time is counted on a 1 ms tick input. When the low-power mode strobe arrives, the block takes a snapshot of the current interval and of the high-side-enabled flag.

If at least one high-side output was enabled at entry, the block runs as a cyclic sensing pacer. It emits a one-cycle sense strobe each time the interval elapses, and then starts the next interval. If no high-side output was enabled, it performs one timed wake-up instead. The wake request rises once, stays high, and counting stops. Leaving low-power mode clears the count and drops the wake request. Driving the analog switches is left to other logic.

Top module: `cyc_wake_timer`

## Requirements
- R1: After reset, sense_pulse and wake_req are 0 and the stored interval code is 000.
- R2: The interval code is loaded from cfg_code only when cfg_wr is high and cfg_sel is 1. A write with cfg_sel 0 leaves the code unchanged.
- R3: With ext_mul 0, codes 1 to 7 give an interval of code × 20 ticks (20 to 140 ms).
- R4: With ext_mul 1, codes 1 to 7 give an interval of code × 160 ticks (160 to 1120 ms).
- R5: Code 000 produces no sense strobe and no wake request, whatever the value of ext_mul.
- R6: If hs_any_on is 1 at lp_enter, sense_pulse is high for exactly one clock after each full interval of ticks, and the interval then repeats.
- R7: If hs_any_on is 0 at lp_enter, wake_req rises after one interval and stays high until lp_exit. In this mode sense_pulse never rises, and sense_pulse and wake_req are never high together.
- R8: lp_exit clears the tick count and wake_req. When lp_exit and the final tick of an interval fall in the same cycle, lp_exit wins and neither output rises.
- R9: The interval and the mode are captured at lp_enter. Later code writes, ext_mul changes and hs_any_on changes do not alter a running low-power period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_sel | input | 1 | Select bit of the write: 1 means interval code |
| cfg_code | input | 3 | Interval code written |
| ext_mul | input | 1 | Eightfold interval extension bit |
| lp_enter | input | 1 | Low-power mode entry strobe |
| lp_exit | input | 1 | Low-power mode exit strobe |
| hs_any_on | input | 1 | At least one high-side output enabled |
| sense_pulse | output | 1 | One-cycle cyclic sense strobe |
| wake_req | output | 1 | Timed wake-up request, held |

## Verification
Two pairs of events can fall in the same cycle. One pair is the final tick of an interval and the exit strobe. The bench drives both in one cycle and judges that neither the wake request nor the strobe appears. The other pair is a new code write, with a changed extension bit and high-side flag, made in the middle of a running cyclic period. The bench judges that the next strobe still arrives at the interval captured at entry.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CYCLIC = 2'd1,
    ST_TIMED  = 2'd2,
    ST_HALT   = 2'd3
  } cwt_state_e;
endpackage

// File: rtl/cwt_code_reg.sv
module cwt_code_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              sel,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)            code_q <= '0;
    else if (wr && sel) code_q <= din;
  end
endmodule

// File: rtl/cwt_interval_calc.sv
module cwt_interval_calc #(
  parameter int CODE_W     = 3,
  parameter int STEP_MS    = 20,
  parameter int EXT_FACTOR = 8,
  parameter int CNT_W      = 11
) (
  input  logic [CODE_W-1:0] code,
  input  logic              ext,
  output logic [CNT_W-1:0]  ticks
);
  always_comb begin
    ticks = CNT_W'(int'(code) * STEP_MS * (ext ? EXT_FACTOR : 1));
  end
endmodule

// File: rtl/cwt_tick_counter.sv
module cwt_tick_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             elapsed
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    elapsed = run && tick && (limit != '0) && (cnt_q == limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (elapsed)      cnt_q <= '0;
    else if (run && tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cyc_wake_timer.sv
module cyc_wake_timer #(
  parameter int CODE_W     = 3,
  parameter int STEP_MS    = 20,
  parameter int EXT_FACTOR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              ext_mul,
  input  logic              lp_enter,
  input  logic              lp_exit,
  input  logic              hs_any_on,
  output logic              sense_pulse,
  output logic              wake_req
);
  import cwt_pkg::*;

  localparam int MAX_TICKS = ((1 << CODE_W) - 1) * STEP_MS * EXT_FACTOR;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim_now;
  logic [CNT_W-1:0]  lim_q;
  logic              elapsed;
  logic              start;
  logic              run;
  cwt_state_e        state_q;

  cwt_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel),
    .din(cfg_code), .code_q(code_q)
  );

  cwt_interval_calc #(
    .CODE_W(CODE_W), .STEP_MS(STEP_MS), .EXT_FACTOR(EXT_FACTOR), .CNT_W(CNT_W)
  ) u_calc (
    .code(code_q), .ext(ext_mul), .ticks(lim_now)
  );

  always_comb begin
    start = (state_q == ST_IDLE) && lp_enter && !lp_exit;
    run   = ((state_q == ST_CYCLIC) || (state_q == ST_TIMED)) && !lp_exit;
  end

  cwt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(lp_exit || start), .run(run),
    .tick(ms_tick), .limit(lim_q), .elapsed(elapsed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lim_q       <= '0;
      sense_pulse <= 1'b0;
      wake_req    <= 1'b0;
    end else begin
      sense_pulse <= (state_q == ST_CYCLIC) && elapsed;
      if (lp_exit) begin
        state_q  <= ST_IDLE;
        wake_req <= 1'b0;
      end else if (start) begin
        lim_q <= lim_now;
        if (lim_now == '0)  state_q <= ST_HALT;
        else if (hs_any_on) state_q <= ST_CYCLIC;
        else                state_q <= ST_TIMED;
      end else if ((state_q == ST_TIMED) && elapsed) begin
        wake_req <= 1'b1;
        state_q  <= ST_HALT;
      end
    end
  end
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker (
  input logic clk,
  input logic rst,
  input logic ms_tick,
  input logic lp_exit,
  input logic sense_pulse,
  input logic wake_req
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sense_pulse && !wake_req)); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) sense_pulse |=> !sense_pulse); // R6
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(sense_pulse) |-> $past(ms_tick)); // R6
  AST_WAKE_HELD: assert property (@(posedge clk) disable iff (rst) (wake_req && !lp_exit) |=> wake_req); // R7
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(sense_pulse && wake_req)); // R7
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst) lp_exit |=> (!wake_req && !sense_pulse)); // R8
endmodule

bind cyc_wake_timer cwt_checker chk_i (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .lp_exit(lp_exit),
  .sense_pulse(sense_pulse), .wake_req(wake_req)
);

// File: tb/cyc_wake_timer_tb_top.sv
module cyc_wake_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [2:0] cfg_code = 3'd0;
  logic       ext_mul = 1'b0, lp_enter = 1'b0, lp_exit = 1'b0, hs_any_on = 1'b0;
  logic       sense_pulse, wake_req;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_wake_timer dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_code(cfg_code), .ext_mul(ext_mul), .lp_enter(lp_enter), .lp_exit(lp_exit),
    .hs_any_on(hs_any_on), .sense_pulse(sense_pulse), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic sel, input logic [2:0] code);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_code = code;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic enter_lp(input logic hs);
    @(negedge clk); hs_any_on = hs; lp_enter = 1'b1;
    @(negedge clk); lp_enter = 1'b0;
  endtask

  task automatic exit_lp();
    @(negedge clk); lp_exit = 1'b1;
    @(negedge clk); lp_exit = 1'b0;
  endtask

  // Applies n ticks; reports strobe count, tick index of first/second strobe, first wake tick.
  task automatic run_ticks(input int n, output int pulses, output int p1, output int p2,
                           output int w1);
    pulses = 0; p1 = 0; p2 = 0; w1 = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
      if (sense_pulse) begin
        pulses++;
        if (pulses == 1) p1 = i;
        if (pulses == 2) p2 = i;
      end
      if (wake_req && w1 == 0) w1 = i;
    end
  endtask

  task automatic t_reset();
    int np, a, b, w;
    check(sense_pulse == 1'b0 && wake_req == 1'b0, "R1 outputs after reset", wake_req, 0);
    ext_mul = 1'b0;
    enter_lp(1'b0);
    run_ticks(200, np, a, b, w);
    check(w == 0 && np == 0, "R1 code 000 after reset", w + np, 0);
    exit_lp();
  endtask

  task automatic t_select();
    int np, a, b, w;
    ext_mul = 1'b0;
    write_cfg(1'b1, 3'd2);
    write_cfg(1'b0, 3'd7);
    enter_lp(1'b0);
    run_ticks(60, np, a, b, w);
    check(w == 40, "R2 sel=0 write ignored, R3 code 2 gives 40", w, 40);
    check(np == 0, "R7 no strobe in timed mode", np, 0);
    exit_lp();
  endtask

  task automatic t_cyc_short();
    int np, a, b, w;
    ext_mul = 1'b0;
    write_cfg(1'b1, 3'd3);
    enter_lp(1'b1);
    run_ticks(130, np, a, b, w);
    check(a == 60, "R3 first strobe code 3", a, 60);
    check(b == 120, "R6 repeat strobe", b, 120);
    check(np == 2 && w == 0, "R6 strobe count, no wake", np, 2);
    exit_lp();
  endtask

  task automatic t_cyc_long();
    int np, a, b, w;
    ext_mul = 1'b1;
    write_cfg(1'b1, 3'd1);
    enter_lp(1'b1);
    run_ticks(330, np, a, b, w);
    check(a == 160, "R4 ext code 1 first strobe", a, 160);
    check(b == 320, "R4 ext code 1 second strobe", b, 320);
    exit_lp();
  endtask

  task automatic t_timed_long();
    int np, a, b, w;
    ext_mul = 1'b1;
    write_cfg(1'b1, 3'd5);
    enter_lp(1'b0);
    run_ticks(900, np, a, b, w);
    check(w == 800, "R4 ext code 5 wake at 800", w, 800);
    check(wake_req == 1'b1, "R7 wake held", wake_req, 1);
    check(np == 0, "R7 no strobe timed", np, 0);
    exit_lp();
    check(wake_req == 1'b0, "R8 exit clears wake", wake_req, 0);
  endtask

  task automatic t_zero();
    int np, a, b, w;
    ext_mul = 1'b1;
    write_cfg(1'b1, 3'd0);
    enter_lp(1'b1);
    run_ticks(1200, np, a, b, w);
    check(np == 0 && w == 0, "R5 code 000 ext 1 silent", np + w, 0);
    exit_lp();
  endtask

  task automatic t_exit_restart();
    int np, a, b, w;
    ext_mul = 1'b0;
    write_cfg(1'b1, 3'd1);
    enter_lp(1'b0);
    run_ticks(10, np, a, b, w);
    exit_lp();
    enter_lp(1'b0);
    run_ticks(25, np, a, b, w);
    check(w == 20, "R8 count cleared by exit", w, 20);
    exit_lp();
  endtask

  task automatic t_collide();
    int np, a, b, w;
    ext_mul = 1'b0;
    write_cfg(1'b1, 3'd1);
    enter_lp(1'b0);
    run_ticks(19, np, a, b, w);
    @(negedge clk); ms_tick = 1'b1; lp_exit = 1'b1;
    @(negedge clk); ms_tick = 1'b0; lp_exit = 1'b0;
    check(wake_req == 1'b0, "R8 exit beats final tick", wake_req, 0);
    // captured interval survives mid-period changes
    enter_lp(1'b1);
    run_ticks(10, np, a, b, w);
    write_cfg(1'b1, 3'd7);
    ext_mul = 1'b1; hs_any_on = 1'b0;
    run_ticks(30, np, a, b, w);
    check(a == 10, "R9 interval held after write", a, 10);
    check(b == 30 && w == 0, "R9 cyclic mode held", b, 30);
    exit_lp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_cyc_short();
    t_cyc_long();
    t_timed_long();
    t_zero();
    t_exit_restart();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule